// File: doc/BRIEF.md
# Dual-Address Two-Wire Management Slave

This block is the management end of a pluggable optical link module. It sits on an open-drain two-wire serial bus and answers two 7-bit device addresses. The lower address (`0x50`) opens a fixed identification page. The next one up (`0x51`) opens a diagnostics page. That page mixes stored thresholds and calibration constants, live 16-bit measurement words fed in parallel by the surrounding logic, a status byte built from three hardware flags, and a region that the bus may write.

Both pages share one 8-bit word pointer. A master sets the pointer with a write of one byte after the device address. It can then send data bytes, or issue a repeated START and read any number of bytes in sequence. The pointer steps after every data byte and wraps from 255 to 0.

The stored pages are modelled as plain registers. Their fixed bytes are computed from a seed parameter and the offset. The writable window resets to zero.

Top module: `mtw_mgmt_slave`

## Requirements
- R1: The slave acknowledges device address `0x50` (identification page) and `0x51` (diagnostics page). It does not acknowledge any other address, and it keeps SDA released until the next START.
- R2: A random read works as follows. A write of one word offset, then a repeated START and a read address, returns the byte at that offset. A read that opens without a new offset continues at the current pointer.
- R3: During sequential reads the pointer advances by one after each byte, and offset 255 is followed by offset 0.
- R4: On the identification page, offset k in 0–127 reads `k XOR ID_SEED`, with a default seed of `8'h3C`. Offsets 128–255 read `8'h00`.
- R5: On the diagnostics page, offsets 0–95, 120–127 and 248–255 read `k XOR DIAG_SEED`, with a default seed of `8'hC3`. Offsets 106–109 and 111–119 read `8'h00`.
- R6: Diagnostics offsets 96–105 hold five 16-bit measurement words, two bytes each, in this order: temperature, supply, bias, transmit power, receive power. Word n comes from `meas_words[16n+15:16n]`, and its high byte sits at the even (lower) offset.
- R7: Reading the high byte of a measurement captures the whole word. A later read of its low byte returns the low half of that captured value, even if the input has changed in between.
- R8: Diagnostics offset 110 reads `{5'b0, st_fault, st_nosig, st_notready}`. Bit 2 is the fault flag, bit 1 is loss of signal, and bit 0 is not-ready.
- R9: Data bytes written to diagnostics offsets 128–247 are stored and read back. Consecutive data bytes in one write go to consecutive offsets.
- R10: Data bytes written anywhere else, on the identification page or outside 128–247 on the diagnostics page, are acknowledged but leave the read value unchanged.
- R11: A STOP ends the transaction, and bytes clocked afterwards without a START get no acknowledge. A master NACK after a read byte makes the slave release SDA and stop sending.
- R12: After reset SDA is released and the word pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_oe | output | 1 | Pulls SDA low when 1, releases it when 0 |
| meas_words | input | NUM_MEAS*16 | Live measurement words, word 0 in the low bits |
| st_fault | input | 1 | Transmit fault flag |
| st_nosig | input | 1 | Receive signal lost flag |
| st_notready | input | 1 | Module not yet ready flag |

## Verification
The assertions assume a master that holds each SCL level for several system clocks. They also assume it moves SDA only while SCL is low, except for deliberate START and STOP edges. Given that, the slave's pull on SDA may change only after a falling SCL edge or a bus condition. The bench drives half periods of 16 system clocks and changes SDA three clocks after lowering SCL. START and STOP are formed only with SCL held high for a full half period, so every edge clears the input synchronizer cleanly.

// File: rtl/mtw_pkg.sv
package mtw_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK,
      ST_TX,
      ST_MACK
   } bus_state_t;

   typedef enum logic [1:0] {
      RK_DEV,
      RK_WADDR,
      RK_DATA
   } rx_kind_t;

   localparam int MEAS_W     = 16;
   localparam int MEAS_BASE  = 96;
   localparam int STATUS_OFF = 110;
   localparam int RT_END     = 119;
endpackage

// File: rtl/mtw_line_sync.sv
module mtw_line_sync #(
   parameter int STAGES = 2,
   parameter int W      = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   initial assert (STAGES >= 2) else $error("mtw_line_sync: STAGES below 2");

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[s] <= '1;
         else if (s == 0) pipe[s] <= d;
         else pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/mtw_bus_fsm.sv
module mtw_bus_fsm
   import mtw_pkg::*;
#(
   parameter logic [6:0] ID_ADDR     = 7'h50,
   parameter logic [6:0] DIAG_ADDR   = 7'h51,
   parameter int         SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       scl_i,
   input  logic       sda_i,
   output logic       sda_oe,
   output logic       diag_sel,
   output logic       rd_fire,
   output logic [7:0] rd_off,
   input  logic [7:0] rd_byte,
   output logic       wr_fire,
   output logic [7:0] wr_off,
   output logic [7:0] wr_byte
);
   logic scl_s, sda_s, scl_d, sda_d;
   logic scl_rise, scl_fall, cond_start, cond_stop;
   bus_state_t state;
   rx_kind_t   kind;
   logic [3:0] bitcnt;
   logic [7:0] shreg, txsh, ptr;
   logic       rw, mnack, hit_id, hit_diag;

   mtw_line_sync #(.STAGES(SYNC_STAGES), .W(2)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q({scl_s, sda_s}));

   assign scl_rise   = scl_s & ~scl_d;
   assign scl_fall   = ~scl_s & scl_d;
   assign cond_start = scl_s & scl_d & sda_d & ~sda_s;
   assign cond_stop  = scl_s & scl_d & ~sda_d & sda_s;
   assign hit_id     = (shreg[7:1] == ID_ADDR);
   assign hit_diag   = (shreg[7:1] == DIAG_ADDR);
   assign rd_off     = ptr;
   assign rd_fire    = scl_fall & ~cond_start & ~cond_stop &
                       (((state == ST_ACK) && (kind == RK_DEV) && rw) ||
                        ((state == ST_MACK) && !mnack));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_d <= 1'b1;  sda_d <= 1'b1;
         state <= ST_IDLE;  kind <= RK_DEV;
         bitcnt <= '0;  shreg <= '0;  txsh <= '0;  ptr <= '0;
         rw <= 1'b0;  mnack <= 1'b1;  diag_sel <= 1'b0;  sda_oe <= 1'b0;
         wr_fire <= 1'b0;  wr_off <= '0;  wr_byte <= '0;
      end else begin
         scl_d   <= scl_s;
         sda_d   <= sda_s;
         wr_fire <= 1'b0;
         if (cond_start) begin
            state <= ST_RX;  kind <= RK_DEV;  bitcnt <= '0;  sda_oe <= 1'b0;
         end else if (cond_stop) begin
            state <= ST_IDLE;  sda_oe <= 1'b0;
         end else if (rd_fire) begin
            txsh <= rd_byte;  sda_oe <= ~rd_byte[7];  ptr <= ptr + 8'd1;
            bitcnt <= '0;  state <= ST_TX;
         end else begin
            case (state)
               ST_RX: begin
                  if (scl_rise) begin
                     shreg  <= {shreg[6:0], sda_s};
                     bitcnt <= bitcnt + 4'd1;
                  end else if (scl_fall && bitcnt == 4'd8) begin
                     bitcnt <= '0;
                     state  <= ST_ACK;
                     sda_oe <= 1'b1;
                     case (kind)
                        RK_DEV: begin
                           if (hit_id || hit_diag) begin
                              diag_sel <= hit_diag;
                              rw       <= shreg[0];
                           end else begin
                              state  <= ST_IDLE;
                              sda_oe <= 1'b0;
                           end
                        end
                        RK_WADDR: ptr <= shreg;
                        default: begin
                           wr_fire <= 1'b1;
                           wr_off  <= ptr;
                           wr_byte <= shreg;
                           ptr     <= ptr + 8'd1;
                        end
                     endcase
                  end
               end
               ST_ACK: begin
                  if (scl_fall) begin
                     sda_oe <= 1'b0;
                     state  <= ST_RX;
                     kind   <= (kind == RK_DEV) ? RK_WADDR : RK_DATA;
                  end
               end
               ST_TX: begin
                  if (scl_fall) begin
                     if (bitcnt == 4'd7) begin
                        sda_oe <= 1'b0;
                        state  <= ST_MACK;
                     end else begin
                        bitcnt <= bitcnt + 4'd1;
                        txsh   <= {txsh[6:0], 1'b0};
                        sda_oe <= ~txsh[6];
                     end
                  end
               end
               ST_MACK: begin
                  if (scl_rise) mnack <= sda_s;
                  else if (scl_fall) state <= ST_IDLE;
               end
               default: state <= ST_IDLE;
            endcase
         end
      end
   end

   // R11: the slave's pull on SDA moves only after SCL falls or at a bus condition
   assert_oe_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (!scl_fall && !cond_start && !cond_stop) |=> $stable(sda_oe));
   // R1: nothing is driven while idle
   assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> !sda_oe);
   // R11: line left free while the master answers a read byte
   assert_mack_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_MACK) |-> !sda_oe);
   // R3: every byte fetched for reading advances the pointer by one
   assert_ptr_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_fire |=> (ptr == $past(ptr) + 8'd1));
   // R9: a write strobe always trails the pointer by one
   assert_wr_ptr_R9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fire |-> (ptr == wr_off + 8'd1));
   // R2: reads and writes never fire together
   assert_rw_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_fire, wr_fire}));
endmodule

// File: rtl/mtw_page_map.sv
module mtw_page_map
   import mtw_pkg::*;
#(
   parameter int         NUM_MEAS  = 5,
   parameter logic [7:0] ID_SEED   = 8'h3C,
   parameter logic [7:0] DIAG_SEED = 8'hC3,
   parameter int         USER_LO   = 128,
   parameter int         USER_HI   = 247
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       diag_sel,
   input  logic                       rd_fire,
   input  logic [7:0]                 rd_off,
   output logic [7:0]                 rd_byte,
   input  logic                       wr_fire,
   input  logic [7:0]                 wr_off,
   input  logic [7:0]                 wr_byte,
   input  logic [NUM_MEAS*MEAS_W-1:0] meas_words,
   input  logic                       st_fault,
   input  logic                       st_nosig,
   input  logic                       st_notready
);
   localparam int USER_N   = USER_HI - USER_LO + 1;
   localparam int IW       = $clog2(USER_N);
   localparam int MEAS_END = MEAS_BASE + 2 * NUM_MEAS - 1;

   initial assert (NUM_MEAS >= 1 && MEAS_END < STATUS_OFF)
      else $error("mtw_page_map: measurement block overlaps status");
   initial assert (USER_LO > RT_END && USER_HI <= 255 && USER_HI >= USER_LO)
      else $error("mtw_page_map: bad writable window");

   logic [MEAS_W-1:0] live [NUM_MEAS];
   logic [MEAS_W-1:0] hold [NUM_MEAS];
   logic [7:0]        umem [USER_N];
   logic              in_meas, in_user_rd, in_user_wr;
   logic [2:0]        midx;

   assign in_meas    = (rd_off >= 8'(MEAS_BASE)) && (rd_off <= 8'(MEAS_END));
   assign in_user_rd = (rd_off >= 8'(USER_LO)) && (rd_off <= 8'(USER_HI));
   assign in_user_wr = diag_sel && (wr_off >= 8'(USER_LO)) && (wr_off <= 8'(USER_HI));
   assign midx       = 3'((rd_off - 8'(MEAS_BASE)) >> 1);

   for (genvar k = 0; k < NUM_MEAS; k++) begin : g_meas
      assign live[k] = meas_words[k*MEAS_W +: MEAS_W];
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold[k] <= '0;
         else if (rd_fire && diag_sel && in_meas && !rd_off[0] && midx == 3'(k))
            hold[k] <= live[k];
      end
      // R7: a captured word changes only when its high byte is fetched
      assert_snap_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_fire |=> $stable(hold[k]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < USER_N; i++) umem[i] <= '0;
      end else if (wr_fire && in_user_wr) begin
         umem[IW'(wr_off - 8'(USER_LO))] <= wr_byte;
      end
   end

   always_comb begin
      if (!diag_sel) begin
         rd_byte = rd_off[7] ? 8'h00 : (rd_off ^ ID_SEED);
      end else if (in_meas) begin
         rd_byte = rd_off[0] ? hold[midx][7:0] : live[midx][15:8];
      end else if (rd_off == 8'(STATUS_OFF)) begin
         rd_byte = {5'b0, st_fault, st_nosig, st_notready};
      end else if (rd_off >= 8'(MEAS_BASE) && rd_off <= 8'(RT_END)) begin
         rd_byte = 8'h00;
      end else if (in_user_rd) begin
         rd_byte = umem[IW'(rd_off - 8'(USER_LO))];
      end else begin
         rd_byte = rd_off ^ DIAG_SEED;
      end
   end
endmodule

// File: rtl/mtw_mgmt_slave.sv
module mtw_mgmt_slave
   import mtw_pkg::*;
#(
   parameter logic [6:0] ID_ADDR     = 7'h50,
   parameter logic [6:0] DIAG_ADDR   = 7'h51,
   parameter int         SYNC_STAGES = 2,
   parameter int         NUM_MEAS    = 5,
   parameter logic [7:0] ID_SEED     = 8'h3C,
   parameter logic [7:0] DIAG_SEED   = 8'hC3,
   parameter int         USER_LO     = 128,
   parameter int         USER_HI     = 247
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       scl_i,
   input  logic                       sda_i,
   output logic                       sda_oe,
   input  logic [NUM_MEAS*MEAS_W-1:0] meas_words,
   input  logic                       st_fault,
   input  logic                       st_nosig,
   input  logic                       st_notready
);
   initial assert (ID_ADDR != DIAG_ADDR) else $error("mtw_mgmt_slave: page addresses collide");

   logic       diag_sel, rd_fire, wr_fire;
   logic [7:0] rd_off, rd_byte, wr_off, wr_byte;

   mtw_bus_fsm #(.ID_ADDR(ID_ADDR), .DIAG_ADDR(DIAG_ADDR), .SYNC_STAGES(SYNC_STAGES)) u_bus (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_oe(sda_oe),
      .diag_sel(diag_sel), .rd_fire(rd_fire), .rd_off(rd_off), .rd_byte(rd_byte),
      .wr_fire(wr_fire), .wr_off(wr_off), .wr_byte(wr_byte));

   mtw_page_map #(.NUM_MEAS(NUM_MEAS), .ID_SEED(ID_SEED), .DIAG_SEED(DIAG_SEED),
                  .USER_LO(USER_LO), .USER_HI(USER_HI)) u_map (
      .clk(clk), .rst_n(rst_n), .diag_sel(diag_sel), .rd_fire(rd_fire), .rd_off(rd_off),
      .rd_byte(rd_byte), .wr_fire(wr_fire), .wr_off(wr_off), .wr_byte(wr_byte),
      .meas_words(meas_words), .st_fault(st_fault), .st_nosig(st_nosig),
      .st_notready(st_notready));
endmodule

// File: tb/sim_mtw_mgmt_slave.sv
module sim_mtw_mgmt_slave;
   localparam int H = 16;
   logic clk = 1'b0, rst_n = 1'b0;
   logic m_scl = 1'b1, m_sda_low = 1'b0;
   logic [79:0] meas = '0;
   logic st_fault = 1'b0, st_nosig = 1'b0, st_notready = 1'b0;
   logic sda_oe;
   wire  sda_line = ~(m_sda_low | sda_oe);

   int checks = 0, failures = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] got;
   event       got_ev;
   logic [7:0] umodel [256];

   always #2 clk = ~clk;

   mtw_mgmt_slave u0 (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
      .sda_oe(sda_oe), .meas_words(meas), .st_fault(st_fault), .st_nosig(st_nosig),
      .st_notready(st_notready));

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // reference model built from the requirements
   function automatic logic [7:0] model(input bit dg, input logic [7:0] k);
      if (!dg) return k[7] ? 8'h00 : (k ^ 8'h3C);
      if (k >= 96 && k <= 105) return k[0] ? meas[(k-96)/2*16 +: 8] : meas[(k-96)/2*16+8 +: 8];
      if (k == 110) return {5'b0, st_fault, st_nosig, st_notready};
      if (k >= 106 && k <= 119) return 8'h00;
      if (k >= 128 && k <= 247) return umodel[k];
      return k ^ 8'hC3;
   endfunction

   always begin : monitor
      @(got_ev);
      if (exp_q.size() == 0) chk(1'b0, "queue-empty", got, 0);
      else begin
         logic [7:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         chk(got === e, t, got, e);
      end
   end

   task automatic wt(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask
   task automatic bit_out(input logic b);
      wt(3); m_sda_low = ~b; wt(H); m_scl = 1'b1; wt(H); m_scl = 1'b0;
   endtask
   task automatic bit_in(output logic b);
      wt(3); m_sda_low = 1'b0; wt(H); m_scl = 1'b1; wt(H/2); b = sda_line; wt(H/2); m_scl = 1'b0;
   endtask
   task automatic go_start;
      wt(3); m_sda_low = 1'b0; wt(H); m_scl = 1'b1; wt(H); m_sda_low = 1'b1; wt(H); m_scl = 1'b0;
   endtask
   task automatic go_stop;
      wt(3); m_sda_low = 1'b1; wt(H); m_scl = 1'b1; wt(H); m_sda_low = 1'b0; wt(H);
   endtask
   task automatic send_byte(input logic [7:0] b, output logic ack);
      for (int i = 7; i >= 0; i--) bit_out(b[i]);
      bit_in(ack);
   endtask
   task automatic recv_byte(input bit last);
      logic [7:0] v;
      for (int i = 7; i >= 0; i--) bit_in(v[i]);
      bit_out(last);
      got = v;
      -> got_ev;
   endtask
   task automatic set_ptr(input bit dg, input logic [7:0] off, input string tag);
      logic a;
      go_start;
      send_byte({7'h50 | 7'(dg), 1'b0}, a); chk(a == 1'b0, tag, a, 0);
      send_byte(off, a);                    chk(a == 1'b0, tag, a, 0);
   endtask
   // driver: pushes expected bytes then performs a random read of n bytes
   task automatic rd_run(input bit dg, input logic [7:0] off, input int n, input string tag);
      logic a;
      for (int i = 0; i < n; i++) begin
         exp_q.push_back(model(dg, off + 8'(i)));
         tag_q.push_back(tag);
      end
      set_ptr(dg, off, tag);
      go_start;
      send_byte({7'h50 | 7'(dg), 1'b1}, a); chk(a == 1'b0, tag, a, 0);
      for (int i = 0; i < n; i++) recv_byte(i == n - 1);
      chk(sda_oe == 1'b0, "R11 release after NACK", sda_oe, 0);
      go_stop;
   endtask
   task automatic wr_run(input bit dg, input logic [7:0] off, input logic [7:0] d0,
                         input logic [7:0] d1, input int n, input string tag);
      logic a;
      set_ptr(dg, off, tag);
      send_byte(d0, a); chk(a == 1'b0, tag, a, 0);
      if (n > 1) begin send_byte(d1, a); chk(a == 1'b0, tag, a, 0); end
      go_stop;
      if (dg && off >= 128 && off <= 247) umodel[off] = d0;
      if (dg && n > 1 && off + 1 >= 128 && off + 1 <= 247) umodel[off + 1] = d1;
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin : driver
      logic a;
      for (int i = 0; i < 256; i++) umodel[i] = 8'h00;
      meas = {16'h0F1E, 16'hDEF0, 16'h9ABC, 16'h5678, 16'h1234};
      wt(5); rst_n = 1'b1; wt(5);
      chk(sda_oe == 1'b0 && sda_line == 1'b1, "R12 reset release", sda_oe, 0);
      // R12: read without offset starts at pointer 0 of the diagnostics page
      exp_q.push_back(8'hC3); tag_q.push_back("R12 pointer zero");
      go_start; send_byte({7'h51, 1'b1}, a); chk(a == 1'b0, "R12", a, 0);
      recv_byte(1'b1); go_stop;
      // R1: foreign address stays silent
      go_start; send_byte({7'h52, 1'b0}, a); chk(a == 1'b1, "R1 foreign nack", a, 1);
      send_byte(8'h00, a); chk(a == 1'b1, "R1 silent after nack", a, 1); go_stop;
      // R4 / R2 identification page
      rd_run(1'b0, 8'd5, 1, "R2 R4 id random");
      rd_run(1'b0, 8'd126, 4, "R4 id boundary");
      // R5 diagnostics stored and reserved
      rd_run(1'b1, 8'd16, 1, "R5 threshold");
      rd_run(1'b1, 8'd60, 1, "R5 calibration");
      rd_run(1'b1, 8'd120, 1, "R5 vendor");
      rd_run(1'b1, 8'd106, 1, "R5 reserved");
      rd_run(1'b1, 8'd111, 1, "R5 reserved");
      // R6 measurement block
      rd_run(1'b1, 8'd96, 10, "R6 measurements");
      // R7 capture on high byte
      rd_run(1'b1, 8'd96, 1, "R7 high byte");
      meas[15:0] = 16'hAAAA;
      exp_q.push_back(8'h34); tag_q.push_back("R7 low from capture");
      set_ptr(1'b1, 8'd97, "R7"); go_start; send_byte({7'h51, 1'b1}, a);
      recv_byte(1'b1); go_stop;
      rd_run(1'b1, 8'd96, 2, "R7 fresh capture");
      // R8 status byte
      st_fault = 1'b1; st_notready = 1'b1;
      rd_run(1'b1, 8'd110, 1, "R8 status 101");
      st_fault = 1'b0; st_notready = 1'b0; st_nosig = 1'b1;
      rd_run(1'b1, 8'd110, 1, "R8 status 010");
      // R9 writable window
      wr_run(1'b1, 8'd128, 8'h11, 8'h22, 2, "R9 write");
      rd_run(1'b1, 8'd128, 3, "R9 readback");
      wr_run(1'b1, 8'd247, 8'h5D, 8'h66, 2, "R9 R10 window edge");
      rd_run(1'b1, 8'd246, 3, "R9 R10 edge readback");
      // R10 protected ranges
      wr_run(1'b0, 8'd4, 8'h77, 8'h78, 2, "R10 id write");
      rd_run(1'b0, 8'd4, 2, "R10 id unchanged");
      wr_run(1'b1, 8'd20, 8'h00, 8'h00, 1, "R10 diag write");
      rd_run(1'b1, 8'd20, 1, "R10 diag unchanged");
      // R3 wrap
      rd_run(1'b1, 8'd254, 4, "R3 wrap");
      // R11 stop ends write
      wr_run(1'b1, 8'd140, 8'h44, 8'h00, 1, "R11 write");
      send_byte(8'h99, a); chk(a == 1'b1, "R11 no ack after stop", a, 1);
      go_stop;
      rd_run(1'b1, 8'd140, 2, "R11 stray not stored");
      wt(50);
      chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule